// File: doc/BRIEF.md
# Capture/Compare Timer with Task Pulses

This block is a 32-bit up-counter paired with a bank of capture/compare channels. It is driven entirely by single-cycle task pulses. START and STOP arm and halt the counter, and CLEAR zeroes it. COUNT steps it by one when the block is in counter mode. Each channel has its own CAPTURE pulse, which snapshots the running value into that channel's register. Software can also load and read the channel registers directly.

In timer mode the counter advances on a divided version of an external clock-enable tick. The divide factor is a power of two chosen by a 4-bit prescale setting. A runtime width setting picks 8, 16, 24 or 32 active bits. That width sets both where the counter wraps and how many bits take part in the compare. A channel emits a one-cycle compare pulse only when the counter steps onto its stored value.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter reads 0, the timer is stopped, every compare output is 0 and every channel register reads 0.
- R2: A START pulse sets running from the next cycle, and a STOP pulse clears it. When both arrive in one cycle the timer ends stopped. A STOP cycle also blocks any increment in that same cycle.
- R3: In timer mode (`cfg_counter_mode`=0) with prescale p, the counter rises by one for every 2^p `tick_en` cycles while running. The prescale phase restarts at CLEAR. While stopped the counter holds.
- R4: In counter mode (`cfg_counter_mode`=1), each `task_count` cycle adds one while running. `tick_en` has no effect, and COUNT has no effect while stopped.
- R5: CLEAR sets the counter to 0 at the next edge. It wins over a simultaneous increment and produces no compare pulse.
- R6: `cfg_width` encodes the active width as 0=16, 1=8, 2=24 and 3=32 bits. After 2^w-1 the next increment gives 0.
- R7: A `task_capture[n]` pulse copies the current counter value into channel n. The copy becomes visible on `cc_rd_data` with `cc_rd_sel`=n from the next cycle.
- R8: A `cc_wr_en[n]` cycle loads `cc_wr_data` into channel n. A capture on the same channel in the same cycle takes priority over the write.
- R9: `compare[n]` is high for exactly the one cycle in which `count_val` first shows a new incremented value equal to channel n. Writing a channel to the current counter value raises no pulse.
- R10: The compare uses only the active width's low bits of both the counter and the channel register. Higher channel bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tick for timer mode |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| task_clear | input | 1 | Clear pulse |
| task_count | input | 1 | Step pulse for counter mode |
| task_capture | input | NCH | Per-channel capture pulses |
| cfg_counter_mode | input | 1 | 1 = step on COUNT, 0 = step on prescaled tick |
| cfg_width | input | 2 | Active width code |
| cfg_prescale | input | PSW | Prescale exponent |
| cc_wr_en | input | NCH | Per-channel write strobes |
| cc_wr_data | input | 32 | Write data for channels |
| cc_rd_sel | input | SELW | Channel read select |
| cc_rd_data | output | 32 | Selected channel value |
| count_val | output | 32 | Current counter value |
| running | output | 1 | Timer started |
| compare | output | NCH | Per-channel compare pulses |

## Verification
The assertions assume that the task inputs are clean single-cycle pulses that change only between clock edges. They also assume the configuration is not altered while an increment is in flight. The stimulus holds `cfg_width`, `cfg_prescale` and `cfg_counter_mode` steady throughout each sweep, and changes them only while no step is pending. Counter sweeps alternate stepping and idle cycles, so that every compare pulse can be checked both for its presence and for its single-cycle length.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int NCH  = 4,
  parameter int PSW  = 4,
  parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            task_start,
  input  logic            task_stop,
  input  logic            task_clear,
  input  logic            task_count,
  input  logic [NCH-1:0]  task_capture,
  input  logic            cfg_counter_mode,
  input  logic [1:0]      cfg_width,
  input  logic [PSW-1:0]  cfg_prescale,
  input  logic [NCH-1:0]  cc_wr_en,
  input  logic [31:0]     cc_wr_data,
  input  logic [SELW-1:0] cc_rd_sel,
  output logic [31:0]     cc_rd_data,
  output logic [31:0]     count_val,
  output logic            running,
  output logic [NCH-1:0]  compare
);
  localparam int PREW = (1 << PSW) - 1;

  logic            run_q;
  logic [31:0]     cnt_q;
  logic [PREW-1:0] pre_q;
  logic [31:0]     cc_q [NCH];
  logic [NCH-1:0]  cmp_q;
  logic [31:0]     wmask;

  always_comb begin
    case (cfg_width)
      2'd0:    wmask = 32'h0000_FFFF;
      2'd1:    wmask = 32'h0000_00FF;
      2'd2:    wmask = 32'h00FF_FFFF;
      default: wmask = 32'hFFFF_FFFF;
    endcase
  end

  wire [PREW-1:0] pmask = ~({PREW{1'b1}} << cfg_prescale);
  wire        live  = run_q && !task_stop;
  wire        tstep = tick_en && ((pre_q & pmask) == pmask);
  wire        step  = live && (cfg_counter_mode ? task_count : tstep);
  wire [31:0] nxt   = (cnt_q + 32'd1) & wmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (task_stop)       run_q <= 1'b0;
      else if (task_start) run_q <= 1'b1;
      if (task_clear)      cnt_q <= '0;
      else if (step)       cnt_q <= nxt;
      if (task_clear)      pre_q <= '0;
      else if (live && !cfg_counter_mode && tick_en) pre_q <= pre_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cc_q[g]  <= '0;
        cmp_q[g] <= 1'b0;
      end else begin
        if (task_capture[g])  cc_q[g] <= cnt_q;
        else if (cc_wr_en[g]) cc_q[g] <= cc_wr_data;
        cmp_q[g] <= step && !task_clear && (nxt == (cc_q[g] & wmask));
      end
    end

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      task_capture[g] |=> cc_q[g] == $past(cnt_q)); // R7
    AST_COMPARE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_q[g] |-> $past(run_q) && !$past(task_clear) && !$past(task_stop)); // R9
  end

  assign cc_rd_data = (int'(cc_rd_sel) < NCH) ? cc_q[cc_rd_sel] : '0;
  assign count_val  = cnt_q;
  assign running    = run_q;
  assign compare    = cmp_q;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    task_stop |=> !run_q); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    task_clear |=> cnt_q == 32'd0 && cmp_q == '0); // R5
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !task_clear |=> $stable(cnt_q)); // R3
endmodule

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic tick_en = 0, task_start = 0, task_stop = 0, task_clear = 0, task_count = 0;
  logic [NCH-1:0] task_capture = '0, cc_wr_en = '0;
  logic cfg_counter_mode = 1;
  logic [1:0] cfg_width = 2'd1;
  logic [3:0] cfg_prescale = '0;
  logic [31:0] cc_wr_data = '0;
  logic [1:0] cc_rd_sel = '0;
  logic [31:0] cc_rd_data, count_val;
  logic running;
  logic [NCH-1:0] compare;
  int nchk = 0, nfail = 0;
  logic [31:0] ccv [NCH];
  logic [31:0] exp;

  cc_timer #(.NCH(NCH), .PSW(4)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] ex);
    nchk++;
    if (act !== ex) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, ex);
    end
  endtask

  task automatic clk1();
    @(posedge clk); #1;
    task_start = 0; task_stop = 0; task_clear = 0; task_count = 0;
    task_capture = '0; cc_wr_en = '0;
  endtask

  task automatic rd(int ch, logic [31:0] ex, string req);
    cc_rd_sel = ch[1:0]; #1;
    chk(req, cc_rd_data, ex);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) clk1();
    rst_n = 1; clk1();
    chk("R1 count", count_val, 0);
    chk("R1 running", {31'd0, running}, 0);
    chk("R1 compare", {28'd0, compare}, 0);
    for (int c = 0; c < NCH; c++) rd(c, 0, "R1 cc");

    task_start = 1; task_stop = 1; clk1();
    chk("R2 stop wins", {31'd0, running}, 0);
    task_start = 1; clk1();
    chk("R2 start", {31'd0, running}, 1);

    ccv[0] = 32'h5; ccv[1] = 32'hFF; ccv[2] = 32'h100; ccv[3] = 32'h77;
    tick_en = 1;
    for (int c = 0; c < NCH; c++) begin
      cc_wr_en[c] = 1; cc_wr_data = ccv[c]; clk1();
    end
    tick_en = 0;
    chk("R4 tick ignored", count_val, 0);
    for (int c = 0; c < NCH; c++) rd(c, ccv[c], "R8 write");

    exp = 0;
    for (int i = 0; i < 600; i++) begin
      task_count = 1; clk1();
      exp = (exp + 1) & 32'hFF;
      chk("R6 count8", count_val, exp);
      for (int c = 0; c < NCH; c++)
        chk("R9 R10 compare", {31'd0, compare[c]}, {31'd0, exp == (ccv[c] & 32'hFF)});
      clk1();
      chk("R9 one cycle", {28'd0, compare}, 0);
    end

    task_clear = 1; task_count = 1; clk1();
    chk("R5 clear wins", count_val, 0);
    chk("R5 no compare", {28'd0, compare}, 0);

    repeat (3) begin task_count = 1; clk1(); end
    chk("R4 count", count_val, 3);
    cc_wr_en[0] = 1; cc_wr_data = 32'h3; clk1();
    chk("R9 write no fire", {28'd0, compare}, 0);

    task_capture = 4'b1010; cc_wr_en[1] = 1; cc_wr_data = 32'h99; clk1();
    rd(1, 3, "R8 capture beats write");
    rd(3, 3, "R7 capture");

    task_stop = 1; task_count = 1; clk1();
    chk("R2 stop blocks step", count_val, 3);
    task_count = 1; clk1();
    chk("R4 stopped", count_val, 3);

    cfg_width = 2'd0;
    task_start = 1; clk1();
    task_clear = 1; clk1();
    repeat (65535) begin task_count = 1; clk1(); end
    chk("R6 max16", count_val, 32'hFFFF);
    task_count = 1; clk1();
    chk("R6 wrap16", count_val, 0);

    cfg_counter_mode = 0; cfg_width = 2'd3;
    for (int p = 0; p < 5; p++) begin
      cfg_prescale = p[3:0];
      task_clear = 1; clk1();
      tick_en = 1;
      repeat (40) clk1();
      tick_en = 0;
      chk("R3 prescale", count_val, 32'(40 >> p));
    end
    exp = count_val;
    task_stop = 1; clk1();
    tick_en = 1;
    repeat (10) clk1();
    tick_en = 0;
    chk("R3 stopped hold", count_val, exp);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule